// File: doc/BRIEF.md
# Shared memory pin arbiter

This block decides which of several masters may drive a set of external memory pins that they share. The pins fall into two groups: the command group (row/column strobes, write enable, chip selects) and the wide group (address and data lines). Each master raises a command-group request when it needs only the command pins, or a wide-group request when it also needs the address and data lines. The arbiter answers with a per-master command grant and a per-master wide grant. Everything runs on the bus clock. Each decision uses only the request lines.

The wide group can only be used together with the command group. For that reason the arbiter treats the command pins as the single shared resource, and at most one master owns them at a time. An owner that asks for the wide group gets both grants together, so it never holds one without the other. A grant is registered. Once given, it is kept for as long as the master keeps requesting. When several masters ask for a free arbiter in the same cycle, the winner is chosen in rotating order, starting from the master after the most recent winner.

Top module: `mem_pin_arbiter`

## Requirements
- R1: While reset is low, every grant is low. After reset, the first contended decision goes to master 0.
- R2: Grants are registered. A grant never appears in the cycle its request is first seen. If no master holds a grant and at least one master requests, some master is granted at the next clock edge.
- R3: When a master is newly granted, its command grant rises. On the same edge its wide grant rises if and only if its wide-group request was high.
- R4: At most one bit of the command grant vector is high. A wide grant bit is only ever high together with the command grant bit of the same index.
- R5: A master holding a command grant keeps it for as long as either of its request bits stays high, whatever the other masters request.
- R6: A master's command grant is low in the cycle after both of its request bits are low. Its wide grant is low in the cycle after its wide-group request is low.
- R7: When the owner drops both of its requests while another master is requesting, the other master's grant rises on the same edge that the owner's grant falls.
- R8: When the arbiter is free and several masters request, the winner is the first requesting index after the previous winner, in increasing index order with wrap-around.
- R9: While one master holds a command-only grant, a wide-group request from another master is not granted.
- R10: An owner holding a command-only grant that raises its wide-group request gets its wide grant at the next edge, and its command grant stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all requests are sampled and all grants are updated on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_req | input | N_MST | Command-group request; bit i belongs to master i |
| bus_req | input | N_MST | Wide-group (address/data plus command) request; bit i belongs to master i |
| ctl_gnt | output | N_MST | Command-group grant; bit i belongs to master i |
| bus_gnt | output | N_MST | Wide-group grant; bit i belongs to master i |

## Verification
The hardest situation to reach is a change of owner inside an ongoing contention. In that case the rotation pointer, the upgrade or downgrade of the current owner, and the release edge all act in the same cycle. Typical examples are a command-only owner that releases while the other master waits with a wide-group request, or an owner that raises its wide-group request while the other side is also asking. A single directed sequence cannot cover all of these cases. The stimulus therefore walks every three-cycle sequence of the four request bits without resetting in between, so each such sequence starts from whatever owner and rotation state the previous one left. Each cycle is compared against an arithmetic model of the ownership rules.

// File: rtl/mem_pin_arb_pkg.sv
package mem_pin_arb_pkg;

  // Grant held by one master slice
  typedef enum logic [1:0] {
    GK_NONE = 2'd0,
    GK_CMD  = 2'd1,
    GK_WIDE = 2'd2
  } gnt_kind_e;

  function automatic gnt_kind_e kind_for(input logic owns, input logic wide_req);
    if (!owns)        return GK_NONE;
    else if (wide_req) return GK_WIDE;
    else              return GK_CMD;
  endfunction

endpackage

// File: rtl/mem_pin_rr_pick.sv
module mem_pin_rr_pick #(
  parameter int N_MST = 2,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0] want,
  input  logic [IDX_W-1:0] last_idx,
  output logic             found,
  output logic [IDX_W-1:0] win_idx
);

  // Search starts one past the previous winner and wraps
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    for (int k = 1; k <= N_MST; k++) begin
      int cand;
      cand = (int'(last_idx) + k) % N_MST;
      if (!found && want[cand]) begin
        found   = 1'b1;
        win_idx = IDX_W'(cand);
      end
    end
  end

endmodule

// File: rtl/mem_pin_grant_slice.sv
module mem_pin_grant_slice
  import mem_pin_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic owns_nxt,
  input  logic wide_req,
  output logic cmd_gnt,
  output logic wide_gnt
);

  gnt_kind_e kind_d, kind_q;

  always_comb begin
    kind_d = kind_for(owns_nxt, wide_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kind_q <= GK_NONE;
    else        kind_q <= kind_d;
  end

  assign cmd_gnt  = (kind_q != GK_NONE);
  assign wide_gnt = (kind_q == GK_WIDE);

endmodule

// File: rtl/mem_pin_owner_state.sv
module mem_pin_owner_state #(
  parameter int N_MST = 2,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MST-1:0] want,
  output logic             own_vld_d,
  output logic [IDX_W-1:0] own_idx_d
);

  logic             own_vld_q;
  logic [IDX_W-1:0] own_idx_q;
  logic [IDX_W-1:0] last_q, last_d;
  logic             last_en;
  logic             keep;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;

  mem_pin_rr_pick #(.N_MST(N_MST)) u_pick (
    .want     (want),
    .last_idx (last_q),
    .found    (pick_found),
    .win_idx  (pick_idx)
  );

  // Next owner: the current owner stays while it requests; otherwise rotate
  always_comb begin
    keep      = own_vld_q && want[own_idx_q];
    own_vld_d = 1'b0;
    own_idx_d = own_idx_q;
    last_en   = 1'b0;
    last_d    = last_q;
    if (keep) begin
      own_vld_d = 1'b1;
    end else if (pick_found) begin
      own_vld_d = 1'b1;
      own_idx_d = pick_idx;
      last_en   = 1'b1;
      last_d    = pick_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld_q <= 1'b0;
      own_idx_q <= '0;
    end else begin
      own_vld_q <= own_vld_d;
      own_idx_q <= own_idx_d;
    end
  end

  // Rotation pointer: reset to the last index so master 0 wins first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= IDX_W'(N_MST - 1);
    else if (last_en) last_q <= last_d;
  end

endmodule

// File: rtl/mem_pin_arbiter.sv
module mem_pin_arbiter #(
  parameter int N_MST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MST-1:0] ctl_req,
  input  logic [N_MST-1:0] bus_req,
  output logic [N_MST-1:0] ctl_gnt,
  output logic [N_MST-1:0] bus_gnt
);

  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1;

  logic [N_MST-1:0] want;
  logic             own_vld_d;
  logic [IDX_W-1:0] own_idx_d;

  // A wide-group request implies use of the command pins as well
  assign want = ctl_req | bus_req;

  mem_pin_owner_state #(.N_MST(N_MST)) u_owner (
    .clk       (clk),
    .rst_n     (rst_n),
    .want      (want),
    .own_vld_d (own_vld_d),
    .own_idx_d (own_idx_d)
  );

  for (genvar i = 0; i < N_MST; i++) begin : g_slice
    logic owns_nxt;
    assign owns_nxt = own_vld_d && (own_idx_d == IDX_W'(i));
    mem_pin_grant_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .owns_nxt (owns_nxt),
      .wide_req (bus_req[i]),
      .cmd_gnt  (ctl_gnt[i]),
      .wide_gnt (bus_gnt[i])
    );
  end

endmodule

// File: rtl/mem_pin_arbiter_chk.sv
module mem_pin_arbiter_chk #(
  parameter int N_MST = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_MST-1:0] ctl_req,
  input logic [N_MST-1:0] bus_req,
  input logic [N_MST-1:0] ctl_gnt,
  input logic [N_MST-1:0] bus_gnt
);

  logic [N_MST-1:0] want;
  assign want = ctl_req | bus_req;

  a_r4_cmd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_gnt));

  a_r4_wide_within_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt & ~ctl_gnt) == '0);

  a_r2_free_grants: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_gnt == '0) && (want != '0) |=> (ctl_gnt != '0));

  for (genvar i = 0; i < N_MST; i++) begin : g_m
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_gnt[i] && want[i] |=> ctl_gnt[i]);

    a_r6_cmd_release: assert property (@(posedge clk) disable iff (!rst_n)
      !want[i] |=> !ctl_gnt[i]);

    a_r6_wide_release: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req[i] |=> !bus_gnt[i]);

    a_r3_pair_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_gnt[i]) |-> (bus_gnt[i] == $past(bus_req[i])));

    a_r10_upgrade: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_gnt[i] && bus_req[i] |=> bus_gnt[i]);

    a_r7_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_gnt[i] && !want[i] && ((want & ~(N_MST'(1) << i)) != '0)
      |=> !ctl_gnt[i] && (ctl_gnt != '0));
  end

endmodule

bind mem_pin_arbiter mem_pin_arbiter_chk #(.N_MST(N_MST)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ctl_req (ctl_req),
  .bus_req (bus_req),
  .ctl_gnt (ctl_gnt),
  .bus_gnt (bus_gnt)
);

// File: tb/mem_pin_arbiter_tb.sv
module mem_pin_arbiter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NM = 2;
  localparam int WD_LIMIT = 60000;

  logic          clk;
  logic          rst_n;
  logic [NM-1:0] ctl_req, bus_req;
  logic [NM-1:0] ctl_gnt, bus_gnt;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // Reference ownership state
  int            m_vld, m_own, m_last;
  logic [NM-1:0] m_ctl, m_bus;

  mem_pin_arbiter #(.N_MST(NM)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ctl_req(ctl_req), .bus_req(bus_req),
    .ctl_gnt(ctl_gnt), .bus_gnt(bus_gnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      bad++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [NM-1:0] act, input logic [NM-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_vld = 0; m_own = 0; m_last = NM - 1;
    m_ctl = '0; m_bus = '0;
  endtask

  // Ownership rules from the requirements
  task automatic model_step(input logic [NM-1:0] c, input logic [NM-1:0] b);
    logic [NM-1:0] w;
    w = c | b;
    if (!(m_vld != 0 && w[m_own])) begin
      m_vld = 0;
      for (int k = 1; k <= NM; k++) begin
        int cand;
        cand = (m_last + k) % NM;
        if (m_vld == 0 && w[cand]) begin
          m_vld = 1; m_own = cand; m_last = cand;
        end
      end
    end
    m_ctl = (m_vld != 0) ? (NM'(1) << m_own) : '0;
    m_bus = (m_vld != 0 && b[m_own]) ? (NM'(1) << m_own) : '0;
  endtask

  // Called at a falling edge: apply, wait one cycle, compare
  task automatic stp(input string tag, input logic [NM-1:0] c, input logic [NM-1:0] b);
    ctl_req = c; bus_req = b;
    model_step(c, b);
    @(negedge clk);
    chk({tag, " ctl"}, ctl_gnt, m_ctl);
    chk({tag, " bus"}, bus_gnt, m_bus);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ctl_req = '0; bus_req = '0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset ctl", ctl_gnt, 2'b00);
    chk("R1 reset bus", bus_gnt, 2'b00);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; ctl_req = '0; bus_req = '0;
    @(negedge clk);
    do_reset();

    // R1: simultaneous first request goes to master 0
    stp("R1 first win", 2'b11, 2'b00);
    chk("R1 first win literal", ctl_gnt, 2'b01);
    // R5: held under contention
    stp("R5 hold", 2'b11, 2'b00);
    chk("R5 hold literal", ctl_gnt, 2'b01);
    // R7: owner drops, waiting master takes over on the same edge
    stp("R7 handoff", 2'b10, 2'b00);
    chk("R7 handoff literal", ctl_gnt, 2'b10);
    // R10: upgrade of command-only owner
    stp("R10 upgrade", 2'b10, 2'b10);
    chk("R10 upgrade literal", bus_gnt, 2'b10);
    // R6: wide grant drops, command grant stays
    stp("R6 wide drop", 2'b10, 2'b00);
    chk("R6 wide drop ctl", ctl_gnt, 2'b10);
    chk("R6 wide drop bus", bus_gnt, 2'b00);
    // R9: wide request of master 0 blocked by command-only owner 1
    stp("R9 blocked", 2'b10, 2'b01);
    chk("R9 blocked literal", bus_gnt, 2'b00);
    // R3: released pins go to the waiting wide request, both grants at once
    stp("R3 pair", 2'b00, 2'b01);
    chk("R3 pair ctl", ctl_gnt, 2'b01);
    chk("R3 pair bus", bus_gnt, 2'b01);
    stp("R6 release", 2'b00, 2'b00);
    chk("R6 release literal", ctl_gnt | bus_gnt, 2'b00);
    // R8: last winner was 0, so master 1 wins, then master 0
    stp("R8 rotate a", 2'b11, 2'b00);
    chk("R8 rotate a literal", ctl_gnt, 2'b10);
    stp("R8 idle", 2'b00, 2'b00);
    stp("R8 rotate b", 2'b11, 2'b00);
    chk("R8 rotate b literal", ctl_gnt, 2'b01);
    stp("R2 idle", 2'b00, 2'b00);
    // R2: nothing in the request cycle, grant one edge later
    ctl_req = 2'b00; bus_req = 2'b10;
    model_step(2'b00, 2'b10);
    #1;
    chk("R2 not combinational", ctl_gnt, 2'b00);
    @(negedge clk);
    chk("R2 registered ctl", ctl_gnt, 2'b10);
    chk("R2 registered bus", bus_gnt, 2'b10);

    // Walk all three-cycle sequences of the request bits without reset
    do_reset();
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int c = 0; c < 16; c++) begin
          stp("R4 R5 R8 sweep s1", 2'(a), 2'(a >> 2));
          stp("R6 R7 R9 sweep s2", 2'(b), 2'(b >> 2));
          stp("R3 R10 sweep s3", 2'(c), 2'(c >> 2));
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule